// File: doc/BRIEF.md
# Sliding-Window Scan Address Generator

This block produces a one-dimensional address stream that is organised as a series of scan lines. Each line starts at a moving start pointer and advances by a fixed address stride until the next stride would carry it past a moving end pointer. When a line completes, the start pointer and the end pointer each move by their own signed stride. The window that a line covers therefore slides, grows or shrinks from one line to the next. The scan stops when the start pointer reaches or crosses its stop bound, or when the end pointer reaches or crosses its own stop bound.

Software or a surrounding controller writes the parameter set through a small write port while the block is idle. A start pulse then launches the scan. The block emits at most one address per clock, with a line-end flag on the last address of each line. A done flag is raised after the final address. A hold input stalls the stream at any point without losing state. A relative mode adds a stored offset, such as the last address of an enclosing scan, to both starting pointers.

Top module: `slider_addr_gen`

## Requirements
- R1: After reset, valid_o, eol_o and done_o are all low.
- R2: In the cycle that follows a start pulse, valid_o is high and addr_o equals the initial start pointer. With relative mode off, that pointer is the base0 field (select code 0).
- R3: Within a line, each accepted address is followed by the previous address plus the address stride (select code 6). eol_o marks the address whose next stride would land strictly beyond the current end pointer. A zero stride makes every line a single address.
- R4: After a line, the start pointer moves by the start stride (code 4) and the end pointer moves by the end stride (code 5). The next line begins in the following cycle at the new start pointer.
- R5: The scan ends after a line when the moved start pointer meets or passes its initial value plus the floor field (code 2), or when the moved end pointer meets or passes its initial value plus the ceiling field (code 3). The direction of each test follows the sign of that pointer's stride, and a zero stride never meets its bound. If both pointer strides are zero, the scan ends after one line. At least one line is always produced.
- R6: All strides, floor and ceiling are AW-bit two's-complement values, so lines and pointers may run downward.
- R7: When rel_i is high with the start pulse, the offset field (code 7) is added to both initial pointers, and the stop bounds follow.
- R8: While hold_i is high, valid_o and eol_o are low and no pointer moves. The stream resumes unchanged when hold_i drops.
- R9: done_o rises in the cycle after the final address is accepted and stays high, with valid_o low, until the next start pulse.
- R10: A start pulse during a scan abandons it. valid_o is low in the pulse cycle, and the new scan begins in the next cycle.
- R11: A write with cfg_we_i high stores cfg_data_i into the field named by cfg_sel_i. The stored fields are used at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Parameter write strobe |
| cfg_sel_i | input | 3 | Field select for the write |
| cfg_data_i | input | AW | Field value |
| rel_i | input | 1 | Relative mode, sampled with start_i |
| start_i | input | 1 | Start or restart pulse |
| hold_i | input | 1 | Stall the stream |
| addr_o | output | AW | Current address |
| valid_o | output | 1 | addr_o is a scan address, accepted this cycle |
| eol_o | output | 1 | Last address of the current line |
| done_o | output | 1 | Scan finished, held until next start |

## Verification
The assertions assume that parameter writes happen only while no scan is running. They also assume that every pointer and address stays inside the AW-bit unsigned range, so that no wrap-around occurs. The sweep respects both assumptions: it writes all fields before each start pulse and centres its starting pointers in the address space, with strides and bounds small enough that no line leaves that range. Hold patterns are applied only on alternate runs, at fixed cycle phases. The restart case is the only one that pulses start_i during a scan.

// File: rtl/slider_pkg.sv
package slider_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} seq_state_e;
  typedef enum logic [2:0] {
    F_BASE0 = 3'd0, F_LIMIT0 = 3'd1, F_FLOOR = 3'd2, F_CEIL = 3'd3,
    F_BSTEP = 3'd4, F_LSTEP = 3'd5, F_ASTEP = 3'd6, F_OFFS = 3'd7
  } cfg_field_e;
  localparam int NUM_FIELDS = 8;
endpackage

// File: rtl/slider_cfg.sv
module slider_cfg #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    sel_i,
  input  logic [AW-1:0] data_i,
  output logic [AW-1:0] base0_o,
  output logic [AW-1:0] limit0_o,
  output logic [AW-1:0] floor_o,
  output logic [AW-1:0] ceil_o,
  output logic [AW-1:0] bstep_o,
  output logic [AW-1:0] lstep_o,
  output logic [AW-1:0] astep_o,
  output logic [AW-1:0] offs_o
);
  import slider_pkg::*;

  logic [AW-1:0] fld_q [NUM_FIELDS];

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         fld_q[g] <= '0;
      else if (we_i && (int'(sel_i) == g)) fld_q[g] <= data_i;
    end
  end

  assign base0_o  = fld_q[F_BASE0];
  assign limit0_o = fld_q[F_LIMIT0];
  assign floor_o  = fld_q[F_FLOOR];
  assign ceil_o   = fld_q[F_CEIL];
  assign bstep_o  = fld_q[F_BSTEP];
  assign lstep_o  = fld_q[F_LSTEP];
  assign astep_o  = fld_q[F_ASTEP];
  assign offs_o   = fld_q[F_OFFS];
endmodule

// File: rtl/slider_stepper.sv
// One slider: load, step by signed stride, report when next position reaches bound.
module slider_stepper #(
  parameter int IW        = 10,
  parameter bit INCL      = 1'b1,  // 1: meeting the bound counts; 0: must pass it
  parameter bit ZERO_ENDS = 1'b0   // reach value when stride is zero
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic signed [IW-1:0] load_val_i,
  input  logic                 adv_i,
  input  logic signed [IW-1:0] step_i,
  input  logic signed [IW-1:0] bound_i,
  output logic signed [IW-1:0] pos_o,
  output logic signed [IW-1:0] next_o,
  output logic                 reach_o
);
  logic signed [IW-1:0] pos_q;
  logic up_hit, dn_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (load_i) pos_q <= load_val_i;
    else if (adv_i)  pos_q <= next_o;
  end

  assign pos_o  = pos_q;
  assign next_o = pos_q + step_i;

  if (INCL) begin : g_incl
    assign up_hit = next_o >= bound_i;
    assign dn_hit = next_o <= bound_i;
  end else begin : g_excl
    assign up_hit = next_o > bound_i;
    assign dn_hit = next_o < bound_i;
  end

  always_comb begin
    if (step_i > 0)      reach_o = up_hit;
    else if (step_i < 0) reach_o = dn_hit;
    else                 reach_o = ZERO_ENDS;
  end
endmodule

// File: rtl/slider_ctrl.sv
module slider_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic hold_i,
  input  logic line_end_i,
  input  logic scan_end_i,
  output logic load_o,
  output logic adv_addr_o,
  output logic adv_line_o,
  output logic run_o,
  output logic valid_o,
  output logic done_o
);
  import slider_pkg::*;

  seq_state_e state_q, state_d;
  logic active;

  assign run_o   = state_q == ST_RUN;
  assign done_o  = state_q == ST_DONE;
  assign active  = run_o && !hold_i && !start_i;
  assign valid_o = active;
  assign load_o  = start_i;
  assign adv_addr_o = active && !line_end_i;
  assign adv_line_o = active && line_end_i && !scan_end_i;

  always_comb begin
    state_d = state_q;
    if (start_i)                                state_d = ST_RUN;
    else if (active && line_end_i && scan_end_i) state_d = ST_DONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  p_done_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);
  p_valid_done_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && done_o));
  p_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> run_o);
endmodule

// File: rtl/slider_addr_gen.sv
module slider_addr_gen #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_sel_i,
  input  logic [AW-1:0] cfg_data_i,
  input  logic          rel_i,
  input  logic          start_i,
  input  logic          hold_i,
  output logic [AW-1:0] addr_o,
  output logic          valid_o,
  output logic          eol_o,
  output logic          done_o
);
  localparam int IW = AW + 2;

  logic [AW-1:0] base0, limit0, floor_f, ceil_f, bstep, lstep, astep, offs;
  logic signed [IW-1:0] bstep_s, lstep_s, astep_s, floor_s, ceil_s, offs_s;
  logic signed [IW-1:0] b_init, l_init, floor_end_q, ceil_end_q;
  logic signed [IW-1:0] b_pos, b_next, l_pos, l_next, a_pos, a_next, a_load_val;
  logic b_reach, l_reach, a_reach, both_zero;
  logic load, adv_addr, adv_line, run;

  slider_cfg #(.AW(AW)) u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .sel_i(cfg_sel_i), .data_i(cfg_data_i),
    .base0_o(base0), .limit0_o(limit0), .floor_o(floor_f), .ceil_o(ceil_f),
    .bstep_o(bstep), .lstep_o(lstep), .astep_o(astep), .offs_o(offs)
  );

  assign bstep_s = $signed({{(IW-AW){bstep[AW-1]}}, bstep});
  assign lstep_s = $signed({{(IW-AW){lstep[AW-1]}}, lstep});
  assign astep_s = $signed({{(IW-AW){astep[AW-1]}}, astep});
  assign floor_s = $signed({{(IW-AW){floor_f[AW-1]}}, floor_f});
  assign ceil_s  = $signed({{(IW-AW){ceil_f[AW-1]}}, ceil_f});
  assign offs_s  = rel_i ? $signed({{(IW-AW){1'b0}}, offs}) : '0;
  assign b_init  = $signed({{(IW-AW){1'b0}}, base0}) + offs_s;
  assign l_init  = $signed({{(IW-AW){1'b0}}, limit0}) + offs_s;
  assign both_zero = (bstep == '0) && (lstep == '0);

  // Stop bounds are fixed relative to the initial pointers of this scan.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      floor_end_q <= '0;
      ceil_end_q  <= '0;
    end else if (load) begin
      floor_end_q <= b_init + floor_s;
      ceil_end_q  <= l_init + ceil_s;
    end
  end

  slider_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i, .hold_i,
    .line_end_i(a_reach), .scan_end_i(b_reach || l_reach || both_zero),
    .load_o(load), .adv_addr_o(adv_addr), .adv_line_o(adv_line),
    .run_o(run), .valid_o(valid_o), .done_o(done_o)
  );

  slider_stepper #(.IW(IW), .INCL(1'b1), .ZERO_ENDS(1'b0)) u_base (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(b_init), .adv_i(adv_line),
    .step_i(bstep_s), .bound_i(floor_end_q),
    .pos_o(b_pos), .next_o(b_next), .reach_o(b_reach)
  );

  slider_stepper #(.IW(IW), .INCL(1'b1), .ZERO_ENDS(1'b0)) u_limit (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(l_init), .adv_i(adv_line),
    .step_i(lstep_s), .bound_i(ceil_end_q),
    .pos_o(l_pos), .next_o(l_next), .reach_o(l_reach)
  );

  assign a_load_val = load ? b_init : b_next;

  slider_stepper #(.IW(IW), .INCL(1'b0), .ZERO_ENDS(1'b1)) u_addr (
    .clk_i, .rst_ni, .load_i(load || adv_line), .load_val_i(a_load_val),
    .adv_i(adv_addr), .step_i(astep_s), .bound_i(l_pos),
    .pos_o(a_pos), .next_o(a_next), .reach_o(a_reach)
  );

  assign addr_o = a_pos[AW-1:0];
  assign eol_o  = valid_o && a_reach;

  p_addr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !eol_o |=> addr_o == AW'($past(addr_o) + $past(astep)));
  p_line_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && eol_o |=> done_o || addr_o == AW'($past(b_pos[AW-1:0]) + $past(bstep)));
  p_hold_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && hold_i && !start_i |=> $stable(addr_o) && $stable(b_pos) && $stable(l_pos));
  p_end_after_line_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(eol_o));
  p_first_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !hold_i |=> valid_o || start_i || hold_i);
endmodule

// File: tb/slider_addr_gen_tb_top.sv
`timescale 1ns/1ps
module slider_addr_gen_tb_top;
  localparam int AW = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_we_i = 1'b0, rel_i = 1'b0, start_i = 1'b0, hold_i = 1'b0;
  logic [2:0] cfg_sel_i = '0;
  logic [AW-1:0] cfg_data_i = '0;
  logic [AW-1:0] addr_o;
  logic valid_o, eol_o, done_o;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  int exp_a [0:4095];
  bit exp_e [0:4095];
  bit exp_s [0:4095];
  int exp_n;

  always #2 clk = ~clk;

  slider_addr_gen #(.AW(AW)) dut_i (
    .clk_i(clk), .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_data_i,
    .rel_i, .start_i, .hold_i, .addr_o, .valid_o, .eol_o, .done_o
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input int sel, input int val);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = sel[2:0]; cfg_data_i = val[AW-1:0];
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  // Reference: lines from start pointer toward end pointer, pointers slide per line.
  task automatic model(input int b0, input int l0, input int f, input int c,
                       input int db, input int dl, input int da, input int off);
    int b, l, a, fe, ce, nb, nl;
    bit stop, eol;
    b = b0 + off; l = l0 + off; fe = b + f; ce = l + c;
    exp_n = 0; stop = 1'b0;
    while (!stop && exp_n < 4000) begin
      a = b;
      eol = 1'b0;
      exp_s[exp_n] = 1'b1;
      while (!eol) begin
        if (da == 0) eol = 1'b1;
        else if (da > 0) eol = (a + da) > l;
        else eol = (a + da) < l;
        if (exp_n > 0 && a != b) exp_s[exp_n] = 1'b0;
        exp_a[exp_n] = a; exp_e[exp_n] = eol;
        exp_n++;
        a = a + da;
      end
      nb = b + db; nl = l + dl;
      stop = (db > 0 && nb >= fe) || (db < 0 && nb <= fe) ||
             (dl > 0 && nl >= ce) || (dl < 0 && nl <= ce) || (db == 0 && dl == 0);
      b = nb; l = nl;
    end
  endtask

  task automatic run_scan(input int b0, input int l0, input int f, input int c,
                          input int db, input int dl, input int da,
                          input bit rel, input int off, input bit hmode);
    int idx, cyc, guard;
    string t;
    wr(0, b0); wr(1, l0); wr(2, f); wr(3, c);  // R11 field codes
    wr(4, db); wr(5, dl); wr(6, da); wr(7, off);
    model(b0, l0, f, c, db, dl, da, rel ? off : 0);
    @(negedge clk);
    rel_i = rel; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; rel_i = 1'b0;
    idx = 0; cyc = 0; guard = 0;
    while (idx < exp_n && guard < 8000) begin
      hold_i = hmode && ((cyc % 4) == 1);
      #1;
      if (hold_i) begin
        check(valid_o == 1'b0 && eol_o == 1'b0, "R8 hold", int'(valid_o), 0);
      end else begin
        if (idx == 0) t = rel ? "R7 rel first" : "R2 first";
        else if (exp_s[idx]) t = "R4 line start";
        else if (da < 0) t = "R6 down step";
        else t = "R3 step";
        check(valid_o == 1'b1, {t, " valid"}, int'(valid_o), 1);
        check(int'(addr_o) == exp_a[idx], {t, " addr"}, int'(addr_o), exp_a[idx]);
        check(eol_o == exp_e[idx], "R3 eol", int'(eol_o), int'(exp_e[idx]));
        idx++;
      end
      @(negedge clk);
      cyc++; guard++;
    end
    hold_i = 1'b0;
    #1;
    check(done_o == 1'b1, "R5 end of scan", int'(done_o), 1);
    check(valid_o == 1'b0, "R9 no valid after end", int'(valid_o), 0);
    for (int k = 0; k < 3; k++) @(negedge clk);
    #1;
    check(done_o == 1'b1 && valid_o == 1'b0, "R9 done sticky", int'(done_o), 1);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int da_v [5] = '{-2, -1, 0, 1, 3};
    int db_v [3] = '{-3, 0, 2};
    int dl_v [3] = '{-2, 0, 3};
    int run_n = 0;
    #1;
    check(valid_o == 0 && eol_o == 0 && done_o == 0, "R1 reset", int'(valid_o) + int'(done_o), 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check(valid_o == 0 && done_o == 0, "R1 after release", int'(done_o), 0);

    foreach (db_v[i]) foreach (dl_v[j]) foreach (da_v[k]) begin
      for (int r = 0; r < 2; r++) begin
        int f, c, l0;
        f  = db_v[i] > 0 ? 9 : (db_v[i] < 0 ? -9 : 0);
        c  = dl_v[j] > 0 ? 10 : (dl_v[j] < 0 ? -10 : 0);
        l0 = da_v[k] < 0 ? 94 : 106;
        run_scan(100, l0, f, c, db_v[i], dl_v[j], da_v[k], r == 1, 20, run_n[0]);
        run_n++;
      end
    end

    // Equal start and end pointer: one address per line
    run_scan(120, 120, 6, 6, 2, 2, 1, 1'b0, 0, 1'b0);

    // R10: restart in the middle of a scan
    wr(0, 50); wr(1, 90); wr(2, 30); wr(3, 30); wr(4, 5); wr(5, 5); wr(6, 1); wr(7, 7);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (3) @(negedge clk);
    rel_i = 1'b1; start_i = 1'b1;
    #1;
    check(valid_o == 1'b0, "R10 valid low on restart", int'(valid_o), 0);
    @(negedge clk); start_i = 1'b0; rel_i = 1'b0;
    #1;
    check(valid_o == 1'b1 && int'(addr_o) == 57, "R10 restart addr", int'(addr_o), 57);
    begin
      int g = 0;
      while (!done_o && g < 5000) begin @(negedge clk); #1; g++; end
    end
    check(done_o == 1'b1, "R10 restarted scan ends", int'(done_o), 1);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule